// File: doc/BRIEF.md
# Colour Lookup Table Register Front End

This block holds a colour lookup table of 256 pseudocolour entries and 4 overlay entries, each an 8-bit red, green and blue triple, behind a small 32-bit word-access register window. A host picks an entry by writing an index. It then streams the three components through a single data register, one access per component. A phase counter tracks which component comes next. After the third component the counter moves the index on to the next entry by itself, so a whole table can be loaded or dumped with one index write followed by a burst of data accesses.

A second data offset sends the same component stream to the overlay bank. The low index bits choose the overlay entry. Reads share the phase counter with writes, so reads and writes can be mixed inside one triple. A separate lookup port serves a pixel pipeline. It takes a 9-bit entry number and returns the packed colour. A parameter makes this port combinational or gives it one register stage.

Top module: `pal_dac`

## Requirements
- R1: A full-word write at offset 0 loads the index from data bits 31:24 and sets the phase to 0 (red).
- R2: A full-word write at offset 4 stores data bits 31:24 into pseudocolour entry `index`: red at phase 0, green at phase 1, blue at phase 2.
- R3: Each data access at phase 2 sets the phase to 0 and increments the index modulo 256. Other data accesses only advance the phase by one.
- R4: A full-word write at offset 12 stores into overlay entry 256 + index[1:0] under the same phase rules. It also increments the full 8-bit index after blue. Pseudocolour entry `index` is left untouched.
- R5: A full-word read at any offset returns, in the cycle after it is accepted with `rvalid_o` high, the current phase's component of pseudocolour entry `index` in bits 31:24 and zeros in bits 23:0. The read then advances the phase and index exactly as a data write does.
- R6: After reset, every entry is 0x000000 except entries 255, 256 and 258, which are 0xFFFFFF. The index and the phase are 0.
- R7: An access with any byte enable low has no effect. A full-word write to an offset other than 0, 4 or 12 has no effect.
- R8: The 2-bit phase only takes the values 0, 1 and 2. A stored value of 3 would be decoded as 0.
- R9: The lookup port returns {red[23:16], green[15:8], blue[7:0]} of entry `lut_idx_i`, or 0 for an entry number of 260 or above. With the default zero latency, a host write is visible there in the cycle after it is accepted.
- R10: Reads and writes share one phase counter. A read in the middle of a triple returns the next component, and a following write continues with the component after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Access strobe, one access per cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset inside the register window |
| bus_be_i | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, component in bits 31:24 |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after an accepted read |
| lut_idx_i | input | 9 | Lookup entry number |
| lut_rgb_o | output | 24 | Lookup colour {r,g,b} |

## Verification
Index wrap is tested by loading index 255 and writing a triple. A design that saturated the index, or carried into a 9th bit, would send the next access to the wrong entry. The overlay test uses an index whose low bits differ from its high bits. This catches a design that writes the pseudocolour entry, uses the full index for the overlay, or forgets to increment after an overlay triple. Mixed read/write triples and partial-enable or wrong-offset accesses are tested next. A design with separate read and write phases, or that steps the phase on ignored accesses, would return the wrong component on the following read. The reset values and the out-of-range lookup are checked directly on the lookup port.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  localparam int unsigned COMP_W = 8;
  localparam int unsigned BUS_W  = 32;

  typedef struct packed {
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] b;
  } rgb_t;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2,
    PH_BAD   = 2'd3
  } phase_e;
endpackage

// File: rtl/pal_idx_seq.sv
module pal_idx_seq
  import pal_dac_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output phase_e           phase_o
);
  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;
  phase_e           phase_eff;

  // out-of-range phase decodes as red
  assign phase_eff = (phase_q == PH_BAD) ? PH_RED : phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (load_i) begin
      idx_q   <= load_val_i;
      phase_q <= PH_RED;
    end else if (step_i) begin
      unique case (phase_eff)
        PH_RED:   phase_q <= PH_GREEN;
        PH_GREEN: phase_q <= PH_BLUE;
        default: begin
          phase_q <= PH_RED;
          idx_q   <= idx_q + 1'b1;
        end
      endcase
    end
  end

  assign idx_o   = idx_q;
  assign phase_o = phase_eff;

  p_phase_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != PH_BAD);

  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (idx_q == $past(load_val_i)) && (phase_q == PH_RED));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && phase_q == PH_BLUE) |=>
      (phase_q == PH_RED) && (idx_q == IDX_W'($past(idx_q) + 1'b1)));

  p_step_hold_idx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && phase_q != PH_BLUE) |=> $stable(idx_q));
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_dac_pkg::*;
#(
  parameter int unsigned MAIN_N = 256,
  parameter int unsigned OVL_N  = 4,
  localparam int unsigned ENT_N = MAIN_N + OVL_N,
  localparam int unsigned ENT_W = $clog2(ENT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ENT_W-1:0]  wr_ent_i,
  input  phase_e            wr_comp_i,
  input  logic [COMP_W-1:0] wr_val_i,
  input  logic [ENT_W-1:0]  host_ent_i,
  output rgb_t              host_rgb_o,
  input  logic [ENT_W-1:0]  lut_ent_i,
  output rgb_t              lut_rgb_o
);
  rgb_t tbl [ENT_N];

  function automatic rgb_t reset_val(input int unsigned e);
    if (e == MAIN_N - 1 || e == MAIN_N || e == MAIN_N + 2) return '1;
    return '0;
  endfunction

  for (genvar e = 0; e < ENT_N; e++) begin : g_ent
    logic hit;
    assign hit = wr_en_i && (wr_ent_i == ENT_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tbl[e] <= reset_val(e);
      end else if (hit) begin
        unique case (wr_comp_i)
          PH_GREEN: tbl[e].g <= wr_val_i;
          PH_BLUE:  tbl[e].b <= wr_val_i;
          default:  tbl[e].r <= wr_val_i;
        endcase
      end
    end
  end

  assign host_rgb_o = (host_ent_i < ENT_W'(ENT_N)) ? tbl[host_ent_i] : '0;
  assign lut_rgb_o  = (lut_ent_i  < ENT_W'(ENT_N)) ? tbl[lut_ent_i]  : '0;

  p_write_red_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_comp_i == PH_RED) |=> tbl[$past(wr_ent_i)].r == $past(wr_val_i));

  p_write_green_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_comp_i == PH_GREEN) |=> tbl[$past(wr_ent_i)].g == $past(wr_val_i));

  p_write_blue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_comp_i == PH_BLUE) |=> tbl[$past(wr_ent_i)].b == $past(wr_val_i));
endmodule

// File: rtl/pal_rdfmt.sv
module pal_rdfmt
  import pal_dac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  phase_e           phase_i,
  input  rgb_t             rgb_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             rvalid_o
);
  logic [COMP_W-1:0] comp;

  always_comb begin
    unique case (phase_i)
      PH_GREEN: comp = rgb_i.g;
      PH_BLUE:  comp = rgb_i.b;
      default:  comp = rgb_i.r;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= {comp, {(BUS_W-COMP_W){1'b0}}};
    end
  end

  p_rdata_fmt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> rdata_o[BUS_W-COMP_W-1:0] == '0);

  p_rvalid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_dac_pkg::*;
#(
  parameter int unsigned MAIN_N      = 256,
  parameter int unsigned OVL_N       = 4,
  parameter int unsigned LUT_LATENCY = 0,
  localparam int unsigned ENT_N = MAIN_N + OVL_N,
  localparam int unsigned ENT_W = $clog2(ENT_N),
  localparam int unsigned IDX_W = $clog2(MAIN_N),
  localparam int unsigned OVL_W = $clog2(OVL_N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bus_valid_i,
  input  logic         bus_write_i,
  input  logic [3:0]   bus_addr_i,
  input  logic [3:0]   bus_be_i,
  input  logic [31:0]  bus_wdata_i,
  output logic [31:0]  bus_rdata_o,
  output logic         bus_rvalid_o,
  input  logic [8:0]   lut_idx_i,
  output logic [23:0]  lut_rgb_o
);
  localparam logic [3:0] OFF_INDEX = 4'd0;
  localparam logic [3:0] OFF_MAIN  = 4'd4;
  localparam logic [3:0] OFF_OVL   = 4'd12;

  logic             acc_ok, ld_idx, wr_main, wr_ovl, rd_acc, step;
  logic [IDX_W-1:0] idx;
  phase_e           phase;
  logic [ENT_W-1:0] wr_ent;
  rgb_t             host_rgb, lut_rgb;

  assign acc_ok  = bus_valid_i && (bus_be_i == 4'hF);
  assign ld_idx  = acc_ok &&  bus_write_i && (bus_addr_i == OFF_INDEX);
  assign wr_main = acc_ok &&  bus_write_i && (bus_addr_i == OFF_MAIN);
  assign wr_ovl  = acc_ok &&  bus_write_i && (bus_addr_i == OFF_OVL);
  assign rd_acc  = acc_ok && !bus_write_i;
  assign step    = wr_main || wr_ovl || rd_acc;

  assign wr_ent = wr_ovl ? ENT_W'(MAIN_N) + ENT_W'(idx[OVL_W-1:0]) : ENT_W'(idx);

  pal_idx_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld_idx),
    .load_val_i (bus_wdata_i[31 -: IDX_W]),
    .step_i     (step),
    .idx_o      (idx),
    .phase_o    (phase)
  );

  pal_store #(.MAIN_N(MAIN_N), .OVL_N(OVL_N)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_main || wr_ovl),
    .wr_ent_i   (wr_ent),
    .wr_comp_i  (phase),
    .wr_val_i   (bus_wdata_i[31 -: COMP_W]),
    .host_ent_i (ENT_W'(idx)),
    .host_rgb_o (host_rgb),
    .lut_ent_i  (ENT_W'(lut_idx_i)),
    .lut_rgb_o  (lut_rgb)
  );

  pal_rdfmt u_rdfmt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_acc),
    .phase_i  (phase),
    .rgb_i    (host_rgb),
    .rdata_o  (bus_rdata_o),
    .rvalid_o (bus_rvalid_o)
  );

  if (LUT_LATENCY == 0) begin : g_lut_comb
    assign lut_rgb_o = lut_rgb;
  end else begin : g_lut_reg
    logic [23:0] lut_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lut_q <= '0;
      else         lut_q <= lut_rgb;
    end
    assign lut_rgb_o = lut_q;
  end

  p_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_be_i != 4'hF) |=> $stable(idx) && $stable(phase));

  p_bad_offset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && bus_write_i && bus_addr_i != OFF_INDEX && bus_addr_i != OFF_MAIN &&
     bus_addr_i != OFF_OVL) |=> $stable(idx) && $stable(phase));

  p_one_kind_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ld_idx, wr_main, wr_ovl, rd_acc}) <= 1);
endmodule

// File: tb/pal_dac_bench.sv
module pal_dac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0, be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [8:0]  lidx = '0;
  logic [23:0] lrgb;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pal_dac u_pal_dac (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(wr),
    .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .lut_idx_i(lidx), .lut_rgb_o(lrgb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    valid = 1'b1; wr = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    valid = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(output logic [31:0] d, output logic v);
    @(negedge clk);
    valid = 1'b1; wr = 1'b0; addr = 4'd4; be = 4'hF;
    @(negedge clk);
    valid = 1'b0;
    d = rdata; v = rvalid;
  endtask

  task automatic lut(input int e, output logic [23:0] c);
    lidx = 9'(e);
    #1 c = lrgb;
  endtask

  task automatic t_reset();
    logic [23:0] c;
    logic [31:0] d; logic v;
    lut(0, c);   check("R6 entry0", {8'h0, c}, 32'h0);
    lut(255, c); check("R6 entry255", {8'h0, c}, 32'h00FFFFFF);
    lut(256, c); check("R6 entry256", {8'h0, c}, 32'h00FFFFFF);
    lut(257, c); check("R6 entry257", {8'h0, c}, 32'h0);
    lut(258, c); check("R6 entry258", {8'h0, c}, 32'h00FFFFFF);
    lut(259, c); check("R6 entry259", {8'h0, c}, 32'h0);
    bus_rd(d, v); check("R6 index0 read", d, 32'h0);
    check("R5 rvalid", {31'h0, v}, 32'h1);
  endtask

  task automatic t_triple();
    logic [23:0] c;
    logic [31:0] d; logic v;
    bus_wr(4'd0, 32'h1A00_0000);
    bus_wr(4'd4, 32'h1155_AAAA);
    lut(26, c); check("R9 red visible next cycle", {8'h0, c}, 32'h0011_0000);
    bus_wr(4'd4, 32'h2200_0000);
    bus_wr(4'd4, 32'h33FF_FFFF);
    lut(26, c); check("R2 triple entry26", {8'h0, c}, 32'h0011_2233);
    bus_wr(4'd4, 32'h4400_0000);
    lut(27, c); check("R3 increment to entry27", {8'h0, c}, 32'h0044_0000);
    // read back entry 26 from red through the shared phase
    bus_wr(4'd0, 32'h1A00_0000);
    bus_rd(d, v); check("R5 read red", d, 32'h1100_0000);
    bus_rd(d, v); check("R5 read green", d, 32'h2200_0000);
    bus_rd(d, v); check("R5 read blue", d, 32'h3300_0000);
    bus_rd(d, v); check("R3 read after triple moves to entry27", d, 32'h4400_0000);
  endtask

  task automatic t_wrap();
    logic [23:0] c;
    bus_wr(4'd0, 32'hFF00_0000);
    bus_wr(4'd4, 32'h0100_0000);
    bus_wr(4'd4, 32'h0200_0000);
    bus_wr(4'd4, 32'h0300_0000);
    lut(255, c); check("R2 entry255", {8'h0, c}, 32'h0001_0203);
    bus_wr(4'd4, 32'h7700_0000);
    lut(0, c); check("R3 wrap to entry0", {8'h0, c}, 32'h0077_0000);
    lut(256, c); check("R3 no carry into overlay", {8'h0, c}, 32'h00FF_FFFF);
  endtask

  task automatic t_overlay();
    logic [23:0] c;
    logic [31:0] d; logic v;
    bus_wr(4'd0, 32'h4500_0000); // index 0x45, low bits 01
    bus_wr(4'd12, 32'hA100_0000);
    bus_wr(4'd12, 32'hB200_0000);
    bus_wr(4'd12, 32'hC300_0000);
    lut(257, c); check("R4 overlay 257", {8'h0, c}, 32'h00A1_B2C3);
    lut(69, c);  check("R4 main entry untouched", {8'h0, c}, 32'h0);
    lut(256, c); check("R4 overlay 256 untouched", {8'h0, c}, 32'h00FF_FFFF);
    bus_wr(4'd4, 32'h5500_0000);
    lut(70, c);  check("R4 index incremented after overlay", {8'h0, c}, 32'h0055_0000);
    bus_rd(d, v); check("R4 phase continues", d, 32'h0);
  endtask

  task automatic t_mid_triple();
    logic [23:0] c;
    logic [31:0] d; logic v;
    bus_wr(4'd0, 32'h1A00_0000);
    bus_wr(4'd4, 32'h9900_0000);
    bus_rd(d, v); check("R10 mid-triple read gives green", d, 32'h2200_0000);
    bus_wr(4'd4, 32'h8800_0000);
    lut(26, c); check("R10 write after read lands in blue", {8'h0, c}, 32'h0099_2288);
    bus_rd(d, v); check("R8 fourth access starts next entry", d, 32'h4400_0000);
  endtask

  task automatic t_ignored();
    logic [23:0] c;
    logic [31:0] d; logic v;
    bus_wr(4'd0, 32'h0A00_0000);
    bus_wr(4'd4, 32'hAA00_0000, 4'h8);
    bus_wr(4'd8, 32'hBB00_0000);
    bus_wr(4'd0, 32'h3300_0000, 4'h7);
    lut(10, c); check("R7 ignored writes leave entry10", {8'h0, c}, 32'h0);
    bus_wr(4'd4, 32'h1100_0000);
    lut(10, c); check("R7 red after ignored", {8'h0, c}, 32'h0011_0000);
    bus_rd(d, v); check("R7 phase stepped once", d, 32'h0);
    lut(300, c); check("R9 out-of-range lookup", {8'h0, c}, 32'h0);
    lut(511, c); check("R9 max lookup number", {8'h0, c}, 32'h0);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_triple();
    t_wrap();
    t_overlay();
    t_mid_triple();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule